// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This combinational unit sits between a 32-bit register file and a data memory that is addressed by word. On a store, it turns the low address bits and the access size into a 4-bit byte-enable. It also moves the register data onto the byte lanes that the byte-enable selects. On a load, it takes the addressed byte or halfword out of the returned memory word and widens it to 32 bits, by sign or by zero. The same result path also delivers the upper-immediate value, in which a 16-bit constant fills the top half and the bottom half is cleared.

Lanes are little-endian: byte offset 0 is bits 7:0. A halfword access at an odd address is misaligned, and so is a word access whose address is not a multiple of four. A misaligned access raises a flag, enables no byte lane and suppresses the register write. The pipeline drives one access, or one upper-immediate, per cycle and takes the results back in the same cycle.

Top module: `lsu_lane_align`

## Requirements
- R1: `misalign` is 1 exactly when `acc_en` is 1 and either `acc_size` is 1 (halfword) and `addr[0]` is 1, or `acc_size` is 2 or 3 (word) and `addr[1:0]` is not 0. A byte access (`acc_size` 0) is never misaligned.
- R2: A misaligned access drives `mem_be` to 4'b0000 and `rf_we` to 0.
- R3: An aligned byte store (`acc_size` 0) with byte offset k = `addr[1:0]` drives `mem_be` = 1<<k. `mem_wdata` carries `reg_wdata[7:0]` in bits 8k+7:8k, and all other bits are zero.
- R4: An aligned halfword store with offset k (0 or 2) drives `mem_be` = 3<<k. `mem_wdata` carries `reg_wdata[15:0]` in bits 8k+15:8k, and all other bits are zero.
- R5: An aligned word store drives `mem_be` = 4'b1111 and `mem_wdata` = `reg_wdata`.
- R6: A signed byte or halfword load (`acc_unsigned` 0) returns on `rf_wdata` the item at offset k of `mem_rdata`. Its top bit is copied into all higher bits.
- R7: An unsigned byte or halfword load (`acc_unsigned` 1) returns the same item with zeros in all higher bits.
- R8: An aligned word load returns `mem_rdata` unchanged on `rf_wdata`, whatever `acc_unsigned` is.
- R9: With `lui_en` 1, `rf_wdata` = {`lui_imm`, 16'h0000} and `rf_we` = 1, even if an access is presented at the same time.
- R10: `mem_word_addr` always equals `addr[31:2]`.
- R11: `acc_size` code 3 behaves exactly as word size (code 2).
- R12: Loads leave `mem_be` at 4'b0000. An aligned load sets `rf_we` to 1. A store leaves `rf_we` at 0 unless `lui_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_en | input | 1 | Memory access present this cycle |
| acc_store | input | 1 | 1 for store, 0 for load |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| acc_unsigned | input | 1 | Zero-extend a byte or halfword load |
| addr | input | 32 | Byte address of the access |
| reg_wdata | input | 32 | Source register value for stores |
| mem_rdata | input | 32 | Word returned by the data memory |
| lui_en | input | 1 | Upper-immediate result requested |
| lui_imm | input | 16 | Constant for the upper halfword |
| mem_word_addr | output | 30 | Word address to the memory |
| mem_be | output | 4 | Per-lane write enable |
| mem_wdata | output | 32 | Lane-steered store data |
| rf_wdata | output | 32 | Value for the destination register |
| rf_we | output | 1 | Destination register write enable |
| misalign | output | 1 | Misaligned access flag |

## Verification
The unit holds no state, so a wrong lane selection or a wrong extension rule shows at the ports in the same cycle as the stimulus. It shows as a wrong enable bit, data on the wrong lane, or wrong upper bits. The sweep covers every combination of offset, size code, direction and signedness. Its data patterns have both top-bit polarities in every lane, so a swapped lane or a swapped extension rule cannot match by chance.

// File: rtl/lsu_lane_align.sv
module lsu_lane_align #(
  parameter int ADDR_W = 32
) (
  input  logic              acc_en,
  input  logic              acc_store,
  input  logic [1:0]        acc_size,
  input  logic              acc_unsigned,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       reg_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              lui_en,
  input  logic [15:0]       lui_imm,
  output logic [ADDR_W-3:0] mem_word_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  output logic [31:0]       rf_wdata,
  output logic              rf_we,
  output logic              misalign
);
  logic [1:0]  off;
  logic [4:0]  bit_off;
  logic        is_byte, is_half;
  logic [3:0]  size_mask;
  logic [31:0] src_item;
  logic [31:0] lane_word;
  logic [31:0] load_val;

  assign off     = addr[1:0];
  assign bit_off = {off, 3'b000};
  assign is_byte = (acc_size == 2'd0);
  assign is_half = (acc_size == 2'd1);

  assign misalign = acc_en & ((is_half & off[0]) | (!is_byte & !is_half & (off != 2'd0)));
  assign mem_word_addr = addr[ADDR_W-1:2];

  always_comb begin
    if (is_byte)      size_mask = 4'b0001;
    else if (is_half) size_mask = 4'b0011;
    else              size_mask = 4'b1111;
  end

  always_comb begin
    if (is_byte)      src_item = {24'h0, reg_wdata[7:0]};
    else if (is_half) src_item = {16'h0, reg_wdata[15:0]};
    else              src_item = reg_wdata;
  end

  assign mem_be    = (acc_en & acc_store & !misalign) ? (size_mask << off) : 4'b0000;
  assign mem_wdata = src_item << bit_off;

  assign lane_word = mem_rdata >> bit_off;

  always_comb begin
    if (is_byte)
      load_val = {{24{lane_word[7] & !acc_unsigned}}, lane_word[7:0]};
    else if (is_half)
      load_val = {{16{lane_word[15] & !acc_unsigned}}, lane_word[15:0]};
    else
      load_val = mem_rdata;
  end

  assign rf_wdata = lui_en ? {lui_imm, 16'h0000} : load_val;
  assign rf_we    = lui_en | (acc_en & !acc_store & !misalign);
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk (
  input logic        acc_en,
  input logic        acc_store,
  input logic [1:0]  acc_size,
  input logic        lui_en,
  input logic [15:0] lui_imm,
  input logic [3:0]  mem_be,
  input logic [31:0] rf_wdata,
  input logic        rf_we,
  input logic        misalign
);
  always_comb begin
    // R2
    be_clear_on_misalign_chk: assert (!misalign || mem_be == 4'b0000);
    // R2
    no_write_on_misalign_chk: assert (!misalign || lui_en || !rf_we);
    // R1
    idle_never_misaligned_chk: assert (acc_en || !misalign);
    // R1
    byte_never_misaligned_chk: assert (acc_size != 2'd0 || !misalign);
    // R12
    load_no_be_chk: assert (acc_store || mem_be == 4'b0000);
    // R3
    be_contiguous_chk: assert (mem_be inside {4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                              4'b0011, 4'b1100, 4'b1111});
    // R9
    lui_result_chk: assert (!lui_en || (rf_we && rf_wdata == {lui_imm, 16'h0000}));
  end
endmodule

bind lsu_lane_align lsu_lane_align_chk u_chk (
  .acc_en(acc_en), .acc_store(acc_store), .acc_size(acc_size),
  .lui_en(lui_en), .lui_imm(lui_imm), .mem_be(mem_be),
  .rf_wdata(rf_wdata), .rf_we(rf_we), .misalign(misalign)
);

// File: tb/lsu_lane_align_bench.sv
module lsu_lane_align_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        acc_en, acc_store, acc_unsigned, lui_en;
  logic [1:0]  acc_size;
  logic [31:0] addr, reg_wdata, mem_rdata;
  logic [15:0] lui_imm;
  logic [29:0] mem_word_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, rf_wdata;
  logic        rf_we, misalign;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  lsu_lane_align u_lsu_lane_align (
    .acc_en(acc_en), .acc_store(acc_store), .acc_size(acc_size),
    .acc_unsigned(acc_unsigned), .addr(addr), .reg_wdata(reg_wdata),
    .mem_rdata(mem_rdata), .lui_en(lui_en), .lui_imm(lui_imm),
    .mem_word_addr(mem_word_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .rf_wdata(rf_wdata), .rf_we(rf_we), .misalign(misalign)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [31:0] pats [4] = '{32'h80FF7F01, 32'h7F0180FE, 32'hA5C33C5A, 32'h00000000};

  initial begin
    acc_en = 0; acc_store = 0; acc_size = 0; acc_unsigned = 0; lui_en = 0;
    addr = 0; reg_wdata = 0; mem_rdata = 0; lui_imm = 0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", misalign, 0);
    check("R12 idle be", mem_be, 0);
    check("R12 idle we", rf_we, 0);

    for (int p = 0; p < 4; p++) begin
      for (int o = 0; o < 4; o++) begin
        for (int sz = 0; sz < 4; sz++) begin
          for (int st = 0; st < 2; st++) begin
            for (int un = 0; un < 2; un++) begin
              longint base, nbytes, item, ext, bad, be_exp, wd_exp, mem, reg_v;
              @(negedge clk);
              acc_en = 1; acc_store = st[0]; acc_size = sz[1:0]; acc_unsigned = un[0];
              addr = 32'h1234_5670 + o + 256 * p;
              reg_wdata = pats[p]; mem_rdata = pats[(p + 1) % 4];
              lui_en = 0;
              #5;
              mem = longint'(pats[(p + 1) % 4]);
              reg_v = longint'(pats[p]);
              nbytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
              bad = (o % nbytes != 0) ? 1 : 0;
              base = 2 ** (8 * o);
              check(sz == 3 ? "R11 misalign" : "R1 misalign", misalign, bad);
              check("R10 word addr", mem_word_addr, longint'(addr) / 4);
              if (st == 1) begin
                be_exp = bad ? 0 : ((2 ** nbytes) - 1) * (2 ** o);
                check(nbytes == 1 ? "R3 be" : nbytes == 2 ? "R4 be" : "R5 be",
                      mem_be, be_exp);
                check("R12 store we", rf_we, 0);
                if (!bad) begin
                  wd_exp = ((reg_v % (2 ** (8 * nbytes))) * base) % (2 ** 32);
                  check(nbytes == 1 ? "R3 wdata" : nbytes == 2 ? "R4 wdata" : "R5 wdata",
                        mem_wdata, wd_exp);
                end
              end else begin
                check("R12 load be", mem_be, 0);
                check(bad ? "R2 we" : "R12 load we", rf_we, bad ? 0 : 1);
                if (!bad) begin
                  item = (mem / base) % (2 ** (8 * nbytes));
                  ext = item;
                  if (nbytes < 4 && un == 0 && item >= 2 ** (8 * nbytes - 1))
                    ext = item + (2 ** 32) - (2 ** (8 * nbytes));
                  check(nbytes == 4 ? "R8 word load" : un ? "R7 zero ext" : "R6 sign ext",
                        rf_wdata, ext);
                end
              end
              if (bad) check("R2 be", mem_be, 0);
            end
          end
        end
      end
    end

    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      acc_en = k[0]; acc_store = k[1]; acc_size = 2'd1; addr = 32'h0000_0003;
      lui_en = 1; lui_imm = 16'h8001 + 16'(k * 16'h1111);
      #5;
      check("R9 lui data", rf_wdata, {lui_imm, 16'h0000});
      check("R9 lui we", rf_we, 1);
    end
    @(negedge clk);
    lui_en = 0; acc_en = 0;
    #5;
    check("R1 disabled", misalign, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule